// File: doc/BRIEF.md
# S/PDIF Subframe and Block Sequencer

The sequencer produces the slot-level content of a stereo S/PDIF stream: one slot per clock, 32 slots per subframe, subframes for the first and the second channel taking turns, and frames counted into blocks. In each subframe it chooses the preamble the line encoder must insert. It then places the PCM sample, the validity flag, one user bit, one channel-status bit and an even parity bit. The biphase-mark line encoder downstream turns slots and preamble codes into line symbols. A register front end upstream supplies samples, status words and user words.

Inputs are taken in at fixed points of the stream. The two PCM samples are captured together at the start of every frame, and the sequencer signals a request in that cycle. The two channel-status words, 30 bits each, are captured at the start of every block. Only their 30 bits are sent, and the status bits of all later frames in the block are zero. A status-update request marks the frame after the last programmed status bit. A 32-bit user word is captured each time its bits run out. Its bits are spent one per subframe across both channels, and the bit count restarts at every block start. When the transmit enable is low, the sequencer idles with all counters cleared and a silent output. The captured data stay as they were.

Top module: `spdif_frame_seq`

## Requirements
- R1: While enabled, word_count_o steps 0..31 once per clock. chan_o is 0 for a first-channel subframe and 1 for a second-channel subframe, and the two alternate starting with 0. frame_count_o advances after each second-channel subframe and wraps from FRAMES-1 (default 192 frames per block) to 0.
- R2: pre_sel_o is nonzero only in slots 0..3 of an active subframe, and slot_bit_o is 0 in those slots. The codes are: 1 for block start (frame 0, chan 0), 2 for any other chan 0 subframe, 3 for chan 1, and 0 for none.
- R3: Slots 4..27 carry a 24-bit field LSB first. The SAMPLE_W-bit sample is left-justified in this field and the unused low bits are 0. Both channels' samples are captured on the clock edge that ends slot 0 of chan 0, and audio_req_o is 1 in that cycle only.
- R4: Slot 28 (validity) is always 0.
- R5: Slot 30 of frame f carries bit f of that channel's 30-bit status word when f < 30, and 0 otherwise.
- R6: Both status words are captured on the edge that ends slot 0 of chan 0 in frame 0. Changing the inputs later in the block does not alter the bits sent in that block.
- R7: cs_req_o is 1 only in slot 0 of chan 0 of frame 30.
- R8: Slot 29 carries bit k (k = 0 is the LSB) of the captured user word. k advances by one per subframe, across both channels. It returns to 0 after 31 and at every block start. The word is captured on the edge ending slot 0 of a subframe with k = 0, and user_req_o is 1 in that cycle.
- R9: Slot 31 makes the count of ones over slots 4..31 even.
- R10: Reset, or tx_en_i low at a clock edge, leaves the block idle from the next cycle. In idle, idle_o = 1; word_count_o, frame_count_o and chan_o are 0; slot_bit_o, pre_sel_o and all three requests are 0. A high tx_en_i at an edge while idle starts slot 0, chan 0, frame 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| pcm_ch1_i | input | SAMPLE_W | First-channel sample |
| pcm_ch2_i | input | SAMPLE_W | Second-channel sample |
| cstat_ch1_i | input | CS_BITS | First-channel status word |
| cstat_ch2_i | input | CS_BITS | Second-channel status word |
| user_word_i | input | 32 | User data word |
| slot_bit_o | output | 1 | Data bit of the current slot |
| pre_sel_o | output | 2 | Preamble code for the encoder |
| chan_o | output | 1 | Channel of current subframe |
| word_count_o | output | 5 | Slot index within subframe |
| frame_count_o | output | $clog2(FRAMES) | Frame index within block |
| idle_o | output | 1 | Block idle |
| audio_req_o | output | 1 | Samples captured, next pair wanted |
| user_req_o | output | 1 | User word captured, next wanted |
| cs_req_o | output | 1 | Status words may be rewritten |

## Verification
The bench builds the block with FRAMES = 40 and SAMPLE_W = 20. With 40 frames, block wrap, the return of the block-start preamble, status capture and the user-bit restart at block start happen every 2560 cycles, so several blocks fit in one run. Because FRAMES does not divide evenly into 32-bit user words, the forced user-bit restart at block start is exercised. Ten frames past the status window show the zero padding of the status bits. The 20-bit sample width tests the left justification, with four zero low bits in every audio field.

// File: rtl/spdif_seq_pkg.sv
package spdif_seq_pkg;
  typedef enum logic [1:0] {
    PRE_NONE = 2'd0,
    PRE_BLK  = 2'd1,
    PRE_CH1  = 2'd2,
    PRE_CH2  = 2'd3
  } pre_e;

  localparam int unsigned PRE_SLOTS = 4;
  localparam int unsigned AUD_W     = 24;
  localparam int unsigned AUD_LAST  = PRE_SLOTS + AUD_W - 1;
  localparam int unsigned V_SLOT    = 28;
  localparam int unsigned U_SLOT    = 29;
  localparam int unsigned C_SLOT    = 30;
  localparam int unsigned P_SLOT    = 31;
  localparam int unsigned USER_W    = 32;
endpackage

// File: rtl/sfs_timing.sv
module sfs_timing #(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned FW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  output logic          run_o,
  output logic [4:0]    slot_o,
  output logic          chan_o,
  output logic [FW-1:0] frame_o,
  output logic [4:0]    ubit_o
);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic          run_q, chan_q;
  logic [4:0]    slot_q, ubit_q;
  logic [FW-1:0] frame_q;
  logic          blk_end;

  assign blk_end = chan_q && (frame_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      slot_q  <= '0;
      chan_q  <= 1'b0;
      frame_q <= '0;
      ubit_q  <= '0;
    end else if (!tx_en_i) begin
      run_q   <= 1'b0;
      slot_q  <= '0;
      chan_q  <= 1'b0;
      frame_q <= '0;
      ubit_q  <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        slot_q <= slot_q + 5'd1;
        if (slot_q == 5'd31) begin
          chan_q <= ~chan_q;
          if (chan_q) frame_q <= (frame_q == LAST) ? '0 : frame_q + FW'(1);
          // user bit index restarts with each block
          ubit_q <= (blk_end || ubit_q == 5'd31) ? 5'd0 : ubit_q + 5'd1;
        end
      end
    end
  end

  assign run_o   = run_q;
  assign slot_o  = slot_q;
  assign chan_o  = chan_q;
  assign frame_o = frame_q;
  assign ubit_o  = ubit_q;
endmodule

// File: rtl/sfs_payload.sv
module sfs_payload
  import spdif_seq_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CS_BITS  = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic                block_start_i,
  input  logic                user_load_i,
  input  logic [SAMPLE_W-1:0] pcm_ch1_i,
  input  logic [SAMPLE_W-1:0] pcm_ch2_i,
  input  logic [CS_BITS-1:0]  cstat_ch1_i,
  input  logic [CS_BITS-1:0]  cstat_ch2_i,
  input  logic [USER_W-1:0]   user_word_i,
  output logic [AUD_W-1:0]    aud1_o,
  output logic [AUD_W-1:0]    aud2_o,
  output logic [CS_BITS-1:0]  cs1_o,
  output logic [CS_BITS-1:0]  cs2_o,
  output logic [USER_W-1:0]   uword_o
);
  localparam int unsigned PAD = AUD_W - SAMPLE_W;

  logic [AUD_W-1:0] just1, just2;

  // left-justify into the 24-bit field
  assign just1 = AUD_W'(pcm_ch1_i) << PAD;
  assign just2 = AUD_W'(pcm_ch2_i) << PAD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aud1_o  <= '0;
      aud2_o  <= '0;
      cs1_o   <= '0;
      cs2_o   <= '0;
      uword_o <= '0;
    end else begin
      if (frame_start_i) begin
        aud1_o <= just1;
        aud2_o <= just2;
      end
      if (block_start_i) begin
        cs1_o <= cstat_ch1_i;
        cs2_o <= cstat_ch2_i;
      end
      if (user_load_i) uword_o <= user_word_i;
    end
  end
endmodule

// File: rtl/sfs_slot_mux.sv
module sfs_slot_mux
  import spdif_seq_pkg::*;
#(
  parameter int unsigned CS_BITS = 30,
  parameter int unsigned FW      = 8
) (
  input  logic               run_i,
  input  logic [4:0]         slot_i,
  input  logic               chan_i,
  input  logic [FW-1:0]      frame_i,
  input  logic [4:0]         ubit_i,
  input  logic [AUD_W-1:0]   aud1_i,
  input  logic [AUD_W-1:0]   aud2_i,
  input  logic [CS_BITS-1:0] cs1_i,
  input  logic [CS_BITS-1:0] cs2_i,
  input  logic [USER_W-1:0]  uword_i,
  output logic               bit_o,
  output logic [1:0]         pre_o
);
  logic [AUD_W-1:0]   aud, a_sh;
  logic [CS_BITS-1:0] cs, c_sh;
  logic [USER_W-1:0]  u_sh;
  logic [4:0]         a_idx;
  logic               c_bit, u_bit, par, bit_v;
  pre_e               pre;

  always_comb begin
    aud   = chan_i ? aud2_i : aud1_i;
    cs    = chan_i ? cs2_i : cs1_i;
    a_idx = slot_i - 5'(PRE_SLOTS);
    a_sh  = aud >> a_idx;
    // shifting past the word leaves zero: status padding
    c_sh  = cs >> frame_i;
    u_sh  = uword_i >> ubit_i;
    c_bit = c_sh[0];
    u_bit = u_sh[0];
    par   = ^{aud, u_bit, c_bit};

    bit_v = 1'b0;
    if (slot_i >= 5'(PRE_SLOTS) && slot_i <= 5'(AUD_LAST)) bit_v = a_sh[0];
    else if (slot_i == 5'(U_SLOT)) bit_v = u_bit;
    else if (slot_i == 5'(C_SLOT)) bit_v = c_bit;
    else if (slot_i == 5'(P_SLOT)) bit_v = par;
    bit_o = run_i & bit_v;

    pre = PRE_NONE;
    if (run_i && slot_i < 5'(PRE_SLOTS)) begin
      if (chan_i)              pre = PRE_CH2;
      else if (frame_i == '0)  pre = PRE_BLK;
      else                     pre = PRE_CH1;
    end
    pre_o = pre;
  end
endmodule

// File: rtl/spdif_frame_seq.sv
module spdif_frame_seq
  import spdif_seq_pkg::*;
#(
  parameter int unsigned FRAMES   = 192,
  parameter int unsigned CS_BITS  = 30,
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned FW      = $clog2(FRAMES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_en_i,
  input  logic [SAMPLE_W-1:0] pcm_ch1_i,
  input  logic [SAMPLE_W-1:0] pcm_ch2_i,
  input  logic [CS_BITS-1:0]  cstat_ch1_i,
  input  logic [CS_BITS-1:0]  cstat_ch2_i,
  input  logic [31:0]         user_word_i,
  output logic                slot_bit_o,
  output logic [1:0]          pre_sel_o,
  output logic                chan_o,
  output logic [4:0]          word_count_o,
  output logic [FW-1:0]       frame_count_o,
  output logic                idle_o,
  output logic                audio_req_o,
  output logic                user_req_o,
  output logic                cs_req_o
);
  logic               run, chan;
  logic [4:0]         slot, ubit;
  logic [FW-1:0]      frame;
  logic               sub_start, frame_start, block_start, user_load;
  logic [AUD_W-1:0]   aud1, aud2;
  logic [CS_BITS-1:0] cs1, cs2;
  logic [USER_W-1:0]  uword;

  sfs_timing #(.FRAMES(FRAMES), .FW(FW)) timing_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .run_o   (run),
    .slot_o  (slot),
    .chan_o  (chan),
    .frame_o (frame),
    .ubit_o  (ubit)
  );

  assign sub_start   = run && (slot == 5'd0);
  assign frame_start = sub_start && !chan;
  assign block_start = frame_start && (frame == '0);
  assign user_load   = sub_start && (ubit == 5'd0);

  sfs_payload #(.SAMPLE_W(SAMPLE_W), .CS_BITS(CS_BITS)) payload_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .block_start_i (block_start),
    .user_load_i   (user_load),
    .pcm_ch1_i     (pcm_ch1_i),
    .pcm_ch2_i     (pcm_ch2_i),
    .cstat_ch1_i   (cstat_ch1_i),
    .cstat_ch2_i   (cstat_ch2_i),
    .user_word_i   (user_word_i),
    .aud1_o        (aud1),
    .aud2_o        (aud2),
    .cs1_o         (cs1),
    .cs2_o         (cs2),
    .uword_o       (uword)
  );

  sfs_slot_mux #(.CS_BITS(CS_BITS), .FW(FW)) mux_i (
    .run_i   (run),
    .slot_i  (slot),
    .chan_i  (chan),
    .frame_i (frame),
    .ubit_i  (ubit),
    .aud1_i  (aud1),
    .aud2_i  (aud2),
    .cs1_i   (cs1),
    .cs2_i   (cs2),
    .uword_i (uword),
    .bit_o   (slot_bit_o),
    .pre_o   (pre_sel_o)
  );

  assign chan_o        = chan;
  assign word_count_o  = slot;
  assign frame_count_o = frame;
  assign idle_o        = !run;
  assign audio_req_o   = frame_start;
  assign user_req_o    = user_load;
  assign cs_req_o      = frame_start && (frame == FW'(CS_BITS));
endmodule

// File: rtl/spdif_frame_seq_chk.sv
module spdif_frame_seq_chk #(
  parameter int unsigned FRAMES  = 192,
  parameter int unsigned CS_BITS = 30,
  parameter int unsigned FW      = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic          slot_bit_o,
  input logic [1:0]    pre_sel_o,
  input logic          chan_o,
  input logic [4:0]    word_count_o,
  input logic [FW-1:0] frame_count_o,
  input logic          idle_o,
  input logic          audio_req_o,
  input logic          user_req_o,
  input logic          cs_req_o
);
  // R1
  frame_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(frame_count_o) < int'(FRAMES));

  // R1
  chan_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && tx_en_i && word_count_o == 5'd31) |=> (chan_o != $past(chan_o)));

  // R2
  pre_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_sel_o != 2'd0) |-> (!idle_o && word_count_o < 5'd4 && !slot_bit_o));

  // R2
  pre_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_sel_o == 2'd1) |-> (frame_count_o == '0 && !chan_o));

  // R4
  validity_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && word_count_o == 5'd28) |-> !slot_bit_o);

  // R7
  cs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_req_o |-> (audio_req_o && int'(frame_count_o) == int'(CS_BITS)));

  // R10
  idle_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (word_count_o == 5'd0 && frame_count_o == '0 && !chan_o && !slot_bit_o
                && pre_sel_o == 2'd0 && !audio_req_o && !user_req_o && !cs_req_o));

  // R10
  en_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> idle_o);
endmodule

bind spdif_frame_seq spdif_frame_seq_chk #(
  .FRAMES(FRAMES), .CS_BITS(CS_BITS), .FW(FW)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_en_i       (tx_en_i),
  .slot_bit_o    (slot_bit_o),
  .pre_sel_o     (pre_sel_o),
  .chan_o        (chan_o),
  .word_count_o  (word_count_o),
  .frame_count_o (frame_count_o),
  .idle_o        (idle_o),
  .audio_req_o   (audio_req_o),
  .user_req_o    (user_req_o),
  .cs_req_o      (cs_req_o)
);

// File: tb/spdif_frame_seq_tb_top.sv
module spdif_frame_seq_tb_top;
  localparam int FRAMES   = 40;
  localparam int CS_BITS  = 30;
  localparam int SAMPLE_W = 20;
  localparam int FW       = $clog2(FRAMES);
  localparam int SUB      = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [SAMPLE_W-1:0] pcm1 = '0, pcm2 = '0;
  logic [CS_BITS-1:0]  cs1 = '0, cs2 = '0;
  logic [31:0]         uw = '0;

  logic          slot_bit, chan, idle, a_req, u_req, c_req;
  logic [1:0]    pre_sel;
  logic [4:0]    wcnt;
  logic [FW-1:0] fcnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spdif_frame_seq #(.FRAMES(FRAMES), .CS_BITS(CS_BITS), .SAMPLE_W(SAMPLE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en),
    .pcm_ch1_i(pcm1), .pcm_ch2_i(pcm2), .cstat_ch1_i(cs1), .cstat_ch2_i(cs2),
    .user_word_i(uw), .slot_bit_o(slot_bit), .pre_sel_o(pre_sel), .chan_o(chan),
    .word_count_o(wcnt), .frame_count_o(fcnt), .idle_o(idle),
    .audio_req_o(a_req), .user_req_o(u_req), .cs_req_o(c_req)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference state, advanced from the requirements
  bit m_run, m_chan;
  int m_slot, m_frame, m_ubit;
  logic [SAMPLE_W-1:0] m_p1, m_p2;
  logic [CS_BITS-1:0]  m_c1, m_c2;
  logic [31:0]         m_uw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_chan <= 0; m_slot <= 0; m_frame <= 0; m_ubit <= 0;
      m_p1 <= '0; m_p2 <= '0; m_c1 <= '0; m_c2 <= '0; m_uw <= '0;
    end else begin
      if (m_run && m_slot == 0 && !m_chan) begin      // R3 sample capture
        m_p1 <= pcm1; m_p2 <= pcm2;
        if (m_frame == 0) begin m_c1 <= cs1; m_c2 <= cs2; end   // R6
      end
      if (m_run && m_slot == 0 && m_ubit == 0) m_uw <= uw;       // R8
      if (!tx_en) begin
        m_run <= 0; m_chan <= 0; m_slot <= 0; m_frame <= 0; m_ubit <= 0;
      end else begin
        m_run <= 1;
        if (m_run) begin
          m_slot <= (m_slot + 1) % SUB;
          if (m_slot == SUB - 1) begin
            m_chan <= !m_chan;
            if (m_chan) m_frame <= (m_frame + 1) % FRAMES;
            m_ubit <= ((m_chan && m_frame == FRAMES - 1) || m_ubit == 31) ? 0 : m_ubit + 1;
          end
        end
      end
    end
  end

  logic [23:0] e_aud;
  logic [CS_BITS-1:0] e_cs;
  logic e_c, e_u, e_p, e_bit;
  int e_pre;

  always @(negedge clk) begin
    if (!m_run) begin
      chk("R10", "idle", idle, 1);
      chk("R10", "word_count", wcnt, 0);
      chk("R10", "frame_count", fcnt, 0);
      chk("R10", "chan", chan, 0);
      chk("R10", "slot_bit", slot_bit, 0);
      chk("R10", "pre_sel", pre_sel, 0);
      chk("R10", "requests", {a_req, u_req, c_req}, 0);
    end else begin
      chk("R10", "idle", idle, 0);
      chk("R1", "word_count", wcnt, m_slot);
      chk("R1", "chan", chan, m_chan);
      chk("R1", "frame_count", fcnt, m_frame);
      e_aud = 24'(m_chan ? m_p2 : m_p1) << (24 - SAMPLE_W);
      e_cs  = m_chan ? m_c2 : m_c1;
      e_c   = (m_frame < CS_BITS) ? e_cs[m_frame] : 1'b0;
      e_u   = m_uw[m_ubit];
      e_p   = ^e_aud ^ e_u ^ e_c;
      e_pre = (m_slot < 4) ? (m_chan ? 3 : (m_frame == 0 ? 1 : 2)) : 0;
      chk("R2", "pre_sel", pre_sel, e_pre);
      if (m_slot < 4) chk("R2", "preamble slot bit", slot_bit, 0);
      else if (m_slot < 28) begin
        e_bit = e_aud[m_slot - 4];
        chk("R3", "audio slot bit", slot_bit, e_bit);
      end
      else if (m_slot == 28) chk("R4", "validity bit", slot_bit, 0);
      else if (m_slot == 29) chk("R8", "user bit", slot_bit, e_u);
      else if (m_slot == 30) chk("R5 R6", "status bit", slot_bit, e_c);
      else chk("R9", "parity bit", slot_bit, e_p);
      chk("R3", "audio_req", a_req, (m_slot == 0 && !m_chan));
      chk("R7", "cs_req", c_req, (m_slot == 0 && !m_chan && m_frame == CS_BITS));
      chk("R8", "user_req", u_req, (m_slot == 0 && m_ubit == 0));
    end
  end

  task automatic jiggle();
    if ($urandom % 4 == 0) pcm1 = SAMPLE_W'($urandom);
    if ($urandom % 4 == 0) pcm2 = SAMPLE_W'($urandom);
    if ($urandom % 16 == 0) uw = $urandom;
    if ($urandom % 300 == 0) cs1 = CS_BITS'($urandom);
    if ($urandom % 300 == 0) cs2 = CS_BITS'($urandom);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4242));
    cs1 = 30'h2AC3_5F19;
    cs2 = '1;                       // R5: padding must still send zeros
    uw  = 32'hC001_D00D;
    pcm1 = '1; pcm2 = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tx_en = 1'b1;                   // R10 start
    for (int i = 0; i < 3 * FRAMES * 64; i++) begin
      @(negedge clk);
      if (i == 6 * 64 + 9) begin cs1 = ~cs1; cs2 = 30'h0F0F_0F0F; end  // R6 mid-block change
      else if (i == 400) begin pcm1 = '0; pcm2 = '1; end
      else jiggle();
    end
    tx_en = 1'b0;                   // R10 drop mid-stream
    repeat (12) @(negedge clk);
    tx_en = 1'b1;
    for (int i = 0; i < FRAMES * 64 + 900; i++) begin
      @(negedge clk);
      jiggle();
    end
    rst_n = 1'b0;                   // R10 reset while running
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      jiggle();
    end
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      report();
    end
  end
endmodule